// File: doc/BRIEF.md
# Indirect-Window Interrupt Priority and Source Configuration Bank

This block holds the per-interrupt priority bytes and per-interrupt source-configuration fields of a hart-local interrupt file with 63 usable identities (identity 0 is reserved). Software reaches the storage through an indirect CSR window rather than a memory map. A select value picks a register, and one of six alias data registers picks what that register means. Alias 1 carries four priority bytes. Aliases 2 and 3 carry the configurations of an even/odd pair of interrupts. Aliases 4 to 6 are forbidden inside the window.

On every write to a configuration field the bank makes the value legal before storing it. It keeps only the delegate bit and the source-mode code, and it maps unsupported mode codes to inactive. It also resolves a delegate request according to whether a supervisor interrupt file exists. The stored arrays are exported flat so that the pending logic and the priority selector can use them directly. Read data and the illegal-access flag are registered.

Top module: `irqcfg_bank`

## Requirements
- R1: Only select values 0x1000 to 0x10FF address the bank. Register k is select 0x1000+k. An access with any other select changes no stored state and raises no illegal flag, and a read of it returns 0.
- R2: A read or write inside the window through alias 4, 5 or 6 sets illegal_o in the cycle after the strobe. Such a write changes nothing, and such a read returns 0.
- R3: Through alias 1, register k (k < 16) holds the priorities of interrupts 4k to 4k+3. Interrupt 4k is in bits 7:0, 4k+1 in bits 15:8, 4k+2 in bits 23:16 and 4k+3 in bits 31:24. A write updates all four bytes.
- R4: Through alias 2, register k (k < 32) returns the configuration of interrupt 2k in bits 10:0, and through alias 3 it returns that of interrupt 2k+1. All other bits read 0, and a write through one alias leaves the partner interrupt unchanged.
- R5: A configuration is 11 bits: bit 10 is the delegate bit D and bits 2:0 are the source mode. A write with D=0 and mode 0, 1, 4, 5, 6 or 7 stores exactly that mode with all other bits zero.
- R6: A write with D=0 and mode 2 or 3 stores an all-zero configuration (inactive).
- R7: With a supervisor file present (HAS_SUPV=1), a write with D=1 stores 0x400: D set and bits 9:0 zero.
- R8: Without a supervisor file (HAS_SUPV=0), a write with D=1 clears the whole configuration to 0.
- R9: Identity 0, identities above NUM_IRQ, and registers beyond the implemented ones (alias 1 with k ≥ 16, aliases 2/3 with k ≥ 32) read as 0 and ignore writes.
- R10: Read data is loaded in the cycle after a read strobe and holds until the next read. illegal_o is low in any cycle that does not follow a forbidden access. Stored arrays change only in the cycle after a write strobe.
- R11: After reset all priorities, configurations, the read data and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | SEL_W | Indirect select value |
| alias_i | input | 3 | Alias data register index (1 to 6) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| illegal_o | output | 1 | Registered illegal-access flag |
| prio_o | output | 64*8 | Priority byte of each identity, identity i at bits 8i+7:8i |
| cfg_o | output | 64*11 | Configuration of each identity, identity i at bits 11i+10:11i |

## Verification
There is one register stage between a strobe and every result. Read data, the illegal flag and the exported arrays all show the effect of an access one clock edge after the strobe. The bench drives each strobe for exactly one cycle between falling edges and samples at the falling edge that follows. That places each sample half a cycle after the capturing edge and before the next access. To confirm that illegal_o lasts only one cycle, the bench samples one falling edge later, after an idle cycle. To confirm that read data holds, it samples again after several idle cycles.

// File: rtl/irqcfg_pkg.sv
package irqcfg_pkg;

    localparam int SLOTS     = 64;
    localparam int PRIO_W    = 8;
    localparam int CFG_W     = 11;
    localparam int DATA_W    = 32;
    localparam int MODE_W    = 3;
    localparam int PRIO_PER  = DATA_W / PRIO_W;
    localparam int PRIO_REGS = SLOTS / PRIO_PER;
    localparam int CFG_REGS  = SLOTS / 2;
    localparam int DBIT      = 10;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_PRIO,
        TGT_CFG_EVEN,
        TGT_CFG_ODD
    } tgt_e;

    function automatic logic [SLOTS-1:0] impl_mask(input int n_irq);
        logic [SLOTS-1:0] m;
        for (int i = 0; i < SLOTS; i++) begin
            m[i] = (i >= 1) && (i <= n_irq);
        end
        return m;
    endfunction

    function automatic logic mode_supported(input logic [MODE_W-1:0] m);
        return !((m == 3'd2) || (m == 3'd3));
    endfunction

endpackage

// File: rtl/irqcfg_decode.sv
module irqcfg_decode #(
    parameter int               SEL_W    = 16,
    parameter logic [SEL_W-1:0] BASE_SEL = 16'h1000
) (
    input  logic [SEL_W-1:0]      sel_i,
    input  logic [2:0]            alias_i,
    output logic                  hit_o,
    output logic                  bad_alias_o,
    output irqcfg_pkg::tgt_e      tgt_o,
    output logic [7:0]            idx_o
);
    import irqcfg_pkg::*;

    localparam int WIN_BITS = 8;

    always_comb begin
        hit_o       = (sel_i[SEL_W-1:WIN_BITS] == BASE_SEL[SEL_W-1:WIN_BITS]);
        idx_o       = sel_i[WIN_BITS-1:0];
        bad_alias_o = 1'b0;
        tgt_o       = TGT_NONE;
        if (hit_o) begin
            unique case (alias_i)
                3'd1:                tgt_o = TGT_PRIO;
                3'd2:                tgt_o = TGT_CFG_EVEN;
                3'd3:                tgt_o = TGT_CFG_ODD;
                3'd4, 3'd5, 3'd6:    bad_alias_o = 1'b1;
                default:             tgt_o = TGT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irqcfg_legalize.sv
module irqcfg_legalize #(
    parameter bit HAS_SUPV = 1'b1
) (
    input  logic                                dbit_i,
    input  logic [irqcfg_pkg::MODE_W-1:0]       mode_i,
    output logic [irqcfg_pkg::CFG_W-1:0]        cfg_o
);
    import irqcfg_pkg::*;

    logic [CFG_W-1:0] deleg_val;

    generate
        if (HAS_SUPV) begin : g_supv
            assign deleg_val = CFG_W'(1) << DBIT;
        end else begin : g_nosupv
            assign deleg_val = '0;
        end
    endgenerate

    always_comb begin
        if (dbit_i) begin
            cfg_o = deleg_val;
        end else if (mode_supported(mode_i)) begin
            cfg_o = {{(CFG_W-MODE_W){1'b0}}, mode_i};
        end else begin
            cfg_o = '0;
        end
    end

endmodule

// File: rtl/irqcfg_bank.sv
module irqcfg_bank #(
    parameter int               NUM_IRQ  = 63,
    parameter bit               HAS_SUPV = 1'b1,
    parameter int               SEL_W    = 16,
    parameter logic [SEL_W-1:0] BASE_SEL = 16'h1000
) (
    input  logic                                           clk_i,
    input  logic                                           rst_ni,
    input  logic [SEL_W-1:0]                               sel_i,
    input  logic [2:0]                                     alias_i,
    input  logic                                           rd_i,
    input  logic                                           wr_i,
    input  logic [31:0]                                    wdata_i,
    output logic [31:0]                                    rdata_o,
    output logic                                           illegal_o,
    output logic [irqcfg_pkg::SLOTS*irqcfg_pkg::PRIO_W-1:0] prio_o,
    output logic [irqcfg_pkg::SLOTS*irqcfg_pkg::CFG_W-1:0]  cfg_o
);
    import irqcfg_pkg::*;

    localparam logic [SLOTS-1:0] IMPL = impl_mask(NUM_IRQ);

    typedef struct packed {
        logic [SLOTS-1:0][PRIO_W-1:0] prio;
        logic [SLOTS-1:0][CFG_W-1:0]  cfg;
        logic [DATA_W-1:0]            rdata;
        logic                         illegal;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic             hit;
    logic             bad_alias;
    tgt_e             tgt;
    logic [7:0]       idx;
    logic [CFG_W-1:0] cfg_legal;

    irqcfg_decode #(
        .SEL_W    (SEL_W),
        .BASE_SEL (BASE_SEL)
    ) i_decode (
        .sel_i       (sel_i),
        .alias_i     (alias_i),
        .hit_o       (hit),
        .bad_alias_o (bad_alias),
        .tgt_o       (tgt),
        .idx_o       (idx)
    );

    irqcfg_legalize #(
        .HAS_SUPV (HAS_SUPV)
    ) i_legalize (
        .dbit_i (wdata_i[DBIT]),
        .mode_i (wdata_i[MODE_W-1:0]),
        .cfg_o  (cfg_legal)
    );

    logic              prio_rng;
    logic              cfg_rng;
    logic [5:0]        pbase;
    logic [5:0]        cid;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;

        prio_rng = (idx[7:4] == 4'd0);
        cfg_rng  = (idx[7:5] == 3'd0);
        pbase    = {idx[3:0], 2'b00};
        cid      = {idx[4:0], (tgt == TGT_CFG_ODD)};

        rd_val = '0;
        unique case (tgt)
            TGT_PRIO: begin
                if (prio_rng) begin
                    for (int b = 0; b < PRIO_PER; b++) begin
                        rd_val[b*PRIO_W +: PRIO_W] = st_q.prio[pbase | 6'(b)];
                    end
                end
            end
            TGT_CFG_EVEN, TGT_CFG_ODD: begin
                if (cfg_rng) begin
                    rd_val[CFG_W-1:0] = st_q.cfg[cid];
                end
            end
            default: rd_val = '0;
        endcase

        if ((rd_i || wr_i) && bad_alias) begin
            st_d.illegal = 1'b1;
        end

        if (rd_i) begin
            st_d.rdata = rd_val;
        end

        if (wr_i) begin
            unique case (tgt)
                TGT_PRIO: begin
                    if (prio_rng) begin
                        for (int b = 0; b < PRIO_PER; b++) begin
                            if (IMPL[pbase | 6'(b)]) begin
                                st_d.prio[pbase | 6'(b)] = wdata_i[b*PRIO_W +: PRIO_W];
                            end
                        end
                    end
                end
                TGT_CFG_EVEN, TGT_CFG_ODD: begin
                    if (cfg_rng && IMPL[cid]) begin
                        st_d.cfg[cid] = cfg_legal;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o   = st_q.rdata;
    assign illegal_o = st_q.illegal;
    assign prio_o    = st_q.prio;
    assign cfg_o     = st_q.cfg;

    // R2
    illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rd_i || wr_i) && (sel_i >= BASE_SEL) && (sel_i <= BASE_SEL + SEL_W'(255))
         && (alias_i >= 3'd4) && (alias_i <= 3'd6)) |=> illegal_o);

    // R10
    no_spurious_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_i || wr_i) |=> !illegal_o);

    // R10
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o));

    // R1
    store_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> ($stable(prio_o) && $stable(cfg_o)));

    // R1
    outside_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i[SEL_W-1:8] != BASE_SEL[SEL_W-1:8]) |=> ($stable(prio_o) && $stable(cfg_o)));

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot_chk
            // R7
            dbit_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                cfg_o[g*CFG_W + DBIT] |-> (cfg_o[g*CFG_W +: DBIT] == '0));

            // R6
            mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                mode_supported(cfg_o[g*CFG_W +: MODE_W]));

            if (!HAS_SUPV) begin : g_nosupv
                // R8
                no_deleg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    !cfg_o[g*CFG_W + DBIT]);
            end

            if (!IMPL[g]) begin : g_unimpl
                // R9
                unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (prio_o[g*PRIO_W +: PRIO_W] == '0) && (cfg_o[g*CFG_W +: CFG_W] == '0));
            end
        end
    endgenerate

endmodule

// File: tb/test_irqcfg_bank.sv
module test_irqcfg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sel = '0;
    logic [2:0]  alias_idx = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;

    logic [31:0]     rd_a, rd_b;
    logic            ill_a, ill_b;
    logic [64*8-1:0] prio_a, prio_b;
    logic [64*11-1:0] cfg_a, cfg_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irqcfg_bank #(.NUM_IRQ(63), .HAS_SUPV(1'b1)) i_irqcfg_bank (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .alias_i(alias_idx),
        .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rd_a), .illegal_o(ill_a), .prio_o(prio_a), .cfg_o(cfg_a));

    irqcfg_bank #(.NUM_IRQ(40), .HAS_SUPV(1'b0)) i_irqcfg_bank_nosupv (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .alias_i(alias_idx),
        .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rd_b), .illegal_o(ill_b), .prio_o(prio_b), .cfg_o(cfg_b));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] s, input logic [2:0] a,
                          input logic r, input logic w, input logic [31:0] d);
        @(negedge clk);
        sel = s; alias_idx = a; rd = r; wr = w; wdata = d;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11", "rdata", rd_a, 32'h0);
        chk("R11", "illegal", {31'b0, ill_a}, 32'h0);
        chk("R11", "prio zero", {31'b0, (prio_a == '0)}, 32'h1);
        chk("R11", "cfg zero", {31'b0, (cfg_a == '0)}, 32'h1);
    endtask

    task automatic t_prio_layout;
        access(16'h1001, 3'd1, 1'b0, 1'b1, 32'hA1B2C3D4);
        chk("R3", "prio id4 byte", {24'b0, prio_a[4*8 +: 8]}, 32'hD4);
        chk("R3", "prio id7 byte", {24'b0, prio_a[7*8 +: 8]}, 32'hA1);
        access(16'h1001, 3'd1, 1'b1, 1'b0, 32'h0);
        chk("R3", "prio read k1", rd_a, 32'hA1B2C3D4);
        access(16'h1000, 3'd1, 1'b0, 1'b1, 32'h11223344);
        access(16'h1000, 3'd1, 1'b1, 1'b0, 32'h0);
        chk("R9", "prio k0 id0 zero", rd_a, 32'h11223300);
    endtask

    task automatic t_cfg_pair;
        access(16'h1003, 3'd2, 1'b0, 1'b1, 32'hFFFF_F3FC);
        access(16'h1003, 3'd3, 1'b0, 1'b1, 32'h0000_0007);
        access(16'h1003, 3'd2, 1'b1, 1'b0, 32'h0);
        chk("R5", "id6 mode4 junk dropped", rd_a, 32'h004);
        access(16'h1003, 3'd3, 1'b1, 1'b0, 32'h0);
        chk("R4", "id7 odd alias", rd_a, 32'h007);
        chk("R4", "id6 field in cfg_o", {21'b0, cfg_a[6*11 +: 11]}, 32'h004);
    endtask

    task automatic t_mode_legal;
        access(16'h1005, 3'd2, 1'b0, 1'b1, 32'h1);
        access(16'h1005, 3'd2, 1'b1, 1'b0, 32'h0);
        chk("R5", "mode1 kept", rd_a, 32'h1);
        access(16'h1005, 3'd2, 1'b0, 1'b1, 32'h2);
        access(16'h1005, 3'd2, 1'b1, 1'b0, 32'h0);
        chk("R6", "mode2 to inactive", rd_a, 32'h0);
        access(16'h1005, 3'd2, 1'b0, 1'b1, 32'h6);
        access(16'h1005, 3'd2, 1'b0, 1'b1, 32'h3);
        access(16'h1005, 3'd2, 1'b1, 1'b0, 32'h0);
        chk("R6", "mode3 to inactive", rd_a, 32'h0);
    endtask

    task automatic t_delegate;
        access(16'h1006, 3'd2, 1'b0, 1'b1, 32'h6);
        access(16'h1006, 3'd2, 1'b1, 1'b0, 32'h0);
        chk("R5", "supv preload", rd_a, 32'h6);
        chk("R5", "nosupv preload", rd_b, 32'h6);
        access(16'h1006, 3'd2, 1'b0, 1'b1, 32'h7FF);
        access(16'h1006, 3'd2, 1'b1, 1'b0, 32'h0);
        chk("R7", "supv delegate", rd_a, 32'h400);
        chk("R7", "supv cfg_o id12", {21'b0, cfg_a[12*11 +: 11]}, 32'h400);
        chk("R8", "nosupv delegate clears", rd_b, 32'h0);
    endtask

    task automatic t_illegal_alias;
        access(16'h1001, 3'd4, 1'b0, 1'b1, 32'hDEADBEEF);
        chk("R2", "alias4 write flag", {31'b0, ill_a}, 32'h1);
        access(16'h1001, 3'd1, 1'b1, 1'b0, 32'h0);
        chk("R2", "alias4 write ignored", rd_a, 32'hA1B2C3D4);
        chk("R10", "flag cleared", {31'b0, ill_a}, 32'h0);
        access(16'h1001, 3'd5, 1'b1, 1'b0, 32'h0);
        chk("R2", "alias5 read flag", {31'b0, ill_b}, 32'h1);
        chk("R2", "alias5 read zero", rd_a, 32'h0);
        access(16'h10FF, 3'd6, 1'b0, 1'b1, 32'h1);
        chk("R2", "alias6 top of window", {31'b0, ill_a}, 32'h1);
        @(negedge clk);
        chk("R10", "flag one cycle", {31'b0, ill_a}, 32'h0);
    endtask

    task automatic t_window;
        access(16'h1100, 3'd1, 1'b0, 1'b1, 32'hFFFFFFFF);
        access(16'h1000, 3'd1, 1'b1, 1'b0, 32'h0);
        chk("R1", "write above window ignored", rd_a, 32'h11223300);
        access(16'h1100, 3'd1, 1'b1, 1'b0, 32'h0);
        chk("R1", "read above window", rd_a, 32'h0);
        access(16'h0FFF, 3'd4, 1'b1, 1'b0, 32'h0);
        chk("R1", "alias4 below window no flag", {31'b0, ill_a}, 32'h0);
    endtask

    task automatic t_unimpl;
        access(16'h100A, 3'd1, 1'b0, 1'b1, 32'h55667788);
        access(16'h100A, 3'd1, 1'b1, 1'b0, 32'h0);
        chk("R3", "full bank ids40-43", rd_a, 32'h55667788);
        chk("R9", "ids41-43 unimplemented", rd_b, 32'h00000088);
        access(16'h1014, 3'd3, 1'b0, 1'b1, 32'h6);
        access(16'h1014, 3'd3, 1'b1, 1'b0, 32'h0);
        chk("R9", "cfg id41 full bank", rd_a, 32'h6);
        chk("R9", "cfg id41 unimplemented", rd_b, 32'h0);
        access(16'h1020, 3'd2, 1'b0, 1'b1, 32'h5);
        access(16'h1020, 3'd2, 1'b1, 1'b0, 32'h0);
        chk("R9", "cfg reg beyond 31", rd_a, 32'h0);
        access(16'h1010, 3'd1, 1'b1, 1'b0, 32'h0);
        chk("R9", "prio reg beyond 15", rd_a, 32'h0);
    endtask

    task automatic t_hold;
        access(16'h1003, 3'd3, 1'b1, 1'b0, 32'h0);
        repeat (4) @(negedge clk);
        chk("R10", "rdata holds", rd_a, 32'h007);
        chk("R10", "no flag idle", {31'b0, ill_a}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prio_layout();
        t_cfg_pair();
        t_mode_legal();
        t_delegate();
        t_illegal_alias();
        t_window();
        t_unimpl();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule